// File: doc/BRIEF.md
# Fetch-to-Execute Pipeline Register with Jump Squash

This block is the single register stage that separates instruction fetch from instruction execute in a two-stage processor. On every rising clock edge it captures the fetched instruction word and the program counter that goes with it. It presents both to the execute stage for the following cycle.

The machine has no architectural branch delay slot. When the instruction now held in the register is a jump and its condition has passed, the word fetched in the same cycle is on the wrong path. A multiplexer at the register input then loads the all-zero word in its place, so a harmless no-op moves on into execute.

The program counter output is forced to zero alongside every bubble. Reset also leaves a bubble in the register, so the first real instruction reaches execute one cycle after reset is released. Next-PC selection and condition evaluation sit outside the block, which sees only the already-evaluated `jump_taken` bit. The reset input `rst_n` is expected to be asserted asynchronously and released in step with the clock by logic upstream.

Top module: `fx_barrier`

## Requirements
- R1: While `rst_n` is low, `instr_out` and `pc_out` are both zero.
- R2: When no squash occurs, a rising clock edge copies `instr_in` to `instr_out` and `pc_in` to `pc_out`.
- R3: A squash occurs when the opcode field of `instr_out` (bits 31:28) equals the jump code 4'hF and `jump_taken` is 1. On that edge `instr_out` becomes 32'h00000000.
- R4: On a squashing edge `pc_out` becomes zero.
- R5: `jump_taken` = 1 while `instr_out` holds a non-jump opcode (bits 31:28 not 4'hF) causes no squash, and the fetched word and PC pass through as in R2.
- R6: A jump opcode in `instr_out` with `jump_taken` = 0 causes no squash, and the fetched word and PC pass through as in R2.
- R7: A bubble (all-zero word, opcode 0) never squashes what follows it, even with `jump_taken` = 1. After a taken jump, the instruction fetched next after the bubble therefore reaches `instr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| instr_in | input | 32 | Instruction word from fetch |
| pc_in | input | 24 | Program counter of `instr_in` |
| jump_taken | input | 1 | Condition of the instruction on `instr_out` has passed |
| instr_out | output | 32 | Instruction word presented to execute |
| pc_out | output | 24 | Program counter of `instr_out`, zero for a bubble |

## Verification
The checker assumes that `rst_n` is low from time zero, so the asynchronous clear has settled before the first edge. It also assumes that `jump_taken` refers to the word now on `instr_out` and is stable around each rising edge. The bench changes every input only at the falling edge and keeps reset low from the start, which satisfies both. It derives `jump_taken` freely, including on non-jump words and on bubbles, so the opcode qualification is exercised from both sides.

// File: rtl/fx_barrier_pkg.sv
package fx_barrier_pkg;

  // Source selected for the next register load.
  typedef enum logic {
    SLOT_PASS = 1'b0,
    SLOT_KILL = 1'b1
  } slot_sel_e;

endpackage

// File: rtl/fx_kill_decode.sv
module fx_kill_decode
  import fx_barrier_pkg::*;
#(
  parameter int OPC_W    = 4,
  parameter int JUMP_OPC = 15
) (
  input  logic [OPC_W-1:0] opc_q,
  input  logic             jump_taken,
  output slot_sel_e        sel
);

  localparam logic [OPC_W-1:0] JumpCode = OPC_W'(JUMP_OPC);

  logic is_jump;

  always_comb begin
    is_jump = (opc_q == JumpCode);
    sel     = (is_jump && jump_taken) ? SLOT_KILL : SLOT_PASS;
  end

endmodule

// File: rtl/fx_slot_mux.sv
module fx_slot_mux
  import fx_barrier_pkg::*;
#(
  parameter int W = 32
) (
  input  slot_sel_e    sel,
  input  logic [W-1:0] fetched,
  output logic [W-1:0] loaded
);

  always_comb begin
    unique case (sel)
      SLOT_KILL: loaded = '0;
      default:   loaded = fetched;
    endcase
  end

endmodule

// File: rtl/fx_slot_reg.sv
module fx_slot_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/fx_barrier.sv
module fx_barrier
  import fx_barrier_pkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int PC_W     = 24,
  parameter int OPC_W    = 4,
  parameter int JUMP_OPC = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_in,
  input  logic [PC_W-1:0]    pc_in,
  input  logic               jump_taken,
  output logic [INSTR_W-1:0] instr_out,
  output logic [PC_W-1:0]    pc_out
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int NUM_SLOTS = 2;

  slot_sel_e         sel;
  logic [OPC_W-1:0]  opc_q;
  logic [INSTR_W-1:0] instr_d;
  logic [PC_W-1:0]    pc_d;

  assign opc_q = instr_out[OPC_LSB +: OPC_W];

  fx_kill_decode #(
    .OPC_W   (OPC_W),
    .JUMP_OPC(JUMP_OPC)
  ) i_kill_decode (
    .opc_q     (opc_q),
    .jump_taken(jump_taken),
    .sel       (sel)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_instr
      fx_slot_mux #(.W(INSTR_W)) i_mux (
        .sel    (sel),
        .fetched(instr_in),
        .loaded (instr_d)
      );
      fx_slot_reg #(.W(INSTR_W)) i_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (1'b1),
        .d    (instr_d),
        .q    (instr_out)
      );
    end else begin : g_pc
      fx_slot_mux #(.W(PC_W)) i_mux (
        .sel    (sel),
        .fetched(pc_in),
        .loaded (pc_d)
      );
      fx_slot_reg #(.W(PC_W)) i_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (1'b1),
        .d    (pc_d),
        .q    (pc_out)
      );
    end
  end

endmodule

// File: rtl/fx_barrier_chk.sv
module fx_barrier_chk #(
  parameter int INSTR_W  = 32,
  parameter int PC_W     = 24,
  parameter int OPC_W    = 4,
  parameter int JUMP_OPC = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic [INSTR_W-1:0] instr_in,
  input logic [PC_W-1:0]    pc_in,
  input logic               jump_taken,
  input logic [INSTR_W-1:0] instr_out,
  input logic [PC_W-1:0]    pc_out
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam logic [OPC_W-1:0] JumpCode = OPC_W'(JUMP_OPC);

  logic squash;
  assign squash = (instr_out[OPC_LSB +: OPC_W] == JumpCode) && jump_taken;

  a_r1_reset_bubble: assert property (@(posedge clk)
    !rst_n |-> (instr_out == '0 && pc_out == '0));

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !squash |=> (instr_out == $past(instr_in) && pc_out == $past(pc_in)));

  a_r3_squash_word: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (instr_out == '0));

  a_r4_squash_pc: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (pc_out == '0));

  a_r7_bubble_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_out == '0 && jump_taken) |=> (instr_out == $past(instr_in)));

endmodule

bind fx_barrier fx_barrier_chk #(
  .INSTR_W (INSTR_W),
  .PC_W    (PC_W),
  .OPC_W   (OPC_W),
  .JUMP_OPC(JUMP_OPC)
) i_fx_barrier_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr_in  (instr_in),
  .pc_in     (pc_in),
  .jump_taken(jump_taken),
  .instr_out (instr_out),
  .pc_out    (pc_out)
);

// File: tb/test_fx_barrier.sv
module test_fx_barrier;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr_in;
  logic [23:0] pc_in;
  logic        jump_taken;
  logic [31:0] instr_out;
  logic [23:0] pc_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_instr;
  logic [23:0] exp_pc;

  fx_barrier i_fx_barrier (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_in  (instr_in),
    .pc_in     (pc_in),
    .jump_taken(jump_taken),
    .instr_out (instr_out),
    .pc_out    (pc_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  // One cycle: drive at falling edge, model the edge, compare just after it.
  task automatic step(input logic [31:0] ins, input logic [23:0] pc, input logic tk);
    bit    kill;
    string tag;
    @(negedge clk);
    instr_in   = ins;
    pc_in      = pc;
    jump_taken = tk;
    kill = (exp_instr[31:28] == 4'hF) && tk;
    if (kill)                        tag = "R3";
    else if (exp_instr == 0 && tk)   tag = "R7";
    else if (exp_instr[31:28] == 4'hF) tag = "R6";
    else if (tk)                     tag = "R5";
    else                             tag = "R2";
    @(posedge clk);
    #1;
    if (kill) begin exp_instr = '0; exp_pc = '0; end
    else      begin exp_instr = ins; exp_pc = pc; end
    check(tag, instr_out, exp_instr);
    check(kill ? "R4" : tag, {8'h0, pc_out}, {8'h0, exp_pc});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_in = 32'h1234_5678; pc_in = 24'hABCDEF; jump_taken = 1'b1;
    exp_instr = '0; exp_pc = '0;
    repeat (3) @(negedge clk);
    check("R1", instr_out, 32'h0);
    check("R1", {8'h0, pc_out}, 32'h0);
    rst_n = 1'b1;
    jump_taken = 1'b0;
    #1;
    check("R1", instr_out, 32'h0);

    // Startup bubble then plain stream.
    step(32'h1000_0001, 24'h000000, 1'b1);  // bubble out, taken: R7
    step(32'h2000_0002, 24'h000001, 1'b0);
    step(32'h3000_0003, 24'h000002, 1'b1);  // non-jump taken: R5
    step(32'hF000_0010, 24'h000003, 1'b0);
    step(32'h4000_0004, 24'h000004, 1'b0);  // jump not taken: R6
    step(32'hF000_0020, 24'h000005, 1'b0);
    step(32'h5000_0005, 24'h000006, 1'b1);  // taken jump: R3, R4
    step(32'h6000_0006, 24'h000010, 1'b1);  // bubble + taken: R7
    step(32'hF000_0030, 24'h000011, 1'b0);
    step(32'hF000_0040, 24'h000012, 1'b1);  // jump killed by jump
    step(32'h7000_0007, 24'h000020, 1'b0);

    // Mid-run reset.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", instr_out, 32'h0);
    check("R1", {8'h0, pc_out}, 32'h0);
    exp_instr = '0; exp_pc = '0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 400; i++) begin
      logic [3:0] opc;
      opc = ($urandom % 3 == 0) ? 4'hF : 4'($urandom);
      step({opc, 28'($urandom)}, 24'($urandom), 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule